// File: doc/BRIEF.md
# Operand Bypass and Hazard Unit

This block is the read-after-write hazard logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). One instruction enters the decode stage each cycle. Register operands are read in decode and results are written back in the last stage. The block tracks the destination register and write enable of the instructions in execute, memory and writeback. For the instruction in execute it picks, per operand, between the value read in decode, the result one stage ahead and the result two stages ahead. It carries the execute result down to writeback and owns the register file. A write in writeback is visible to a read in decode in the same cycle, so a third dependent instruction needs no bypass path.

The surrounding pipeline drives the decode-stage register numbers and the execute-stage result. It takes back the two execute operands and a stall flag. While the stall flag is high it must hold its program counter and decode register. When forwarding is switched off, the block stops bypassing and stalls dependent instructions in decode until the producer reaches writeback. Write-after-read and write-after-write hazards cannot arise, because all reads happen in decode and all writes happen in order in writeback.

Top module: `opnd_bypass_unit`

## Requirements
- R1: After reset, `stall` is low, both selects are 00, both operands are zero, and every register reads as zero.
- R2: When an execute-stage source register is nonzero, and equals the destination of the instruction one stage ahead whose write enable is set, that operand's select is 10 (encoding `2'b10`). The operand then carries that instruction's result.
- R3: When the condition of R2 fails, but the source matches a write-enabled nonzero destination two stages ahead, the select is 01 (`2'b01`) and the operand carries that older result.
- R4: When both later stages write the same source register, the younger result (select 10) is used.
- R5: Register 0 always reads as zero and is never forwarded. A write to it is discarded.
- R6: A producer whose write enable is clear is never a bypass source. The select stays 00 (`2'b00`) and the operand is the register-file value.
- R7: A value written in writeback is returned by a decode read of the same register in that cycle. With forwarding on, `stall` never rises, so a producer followed by three consumers costs zero stall cycles.
- R8: With `fwdEnable` low, both selects are 00. A consumer directly behind its producer is stalled exactly 2 cycles. A consumer two positions behind is stalled 1 cycle.
- R9: In every cycle that follows a stall, execute holds a bubble: both selects are 00 and nothing is written back for it.
- R10: With forwarding off, a decode-stage source causes a stall only against a later-stage instruction whose write enable is set and whose destination is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fwdEnable | input | 1 | 1 = bypass, 0 = stall on dependence |
| idRs1 | input | AW | First source register of the decode-stage instruction |
| idRs2 | input | AW | Second source register of the decode-stage instruction |
| idRd | input | AW | Destination register of the decode-stage instruction |
| idRegWrite | input | 1 | Decode-stage instruction writes `idRd` |
| exResult | input | DW | Result produced by the execute-stage instruction |
| stall | output | 1 | Hold fetch and decode; bubble into execute |
| exSelA | output | 2 | First-operand source: 00 register, 01 two ahead, 10 one ahead |
| exSelB | output | 2 | Second-operand source, same encoding |
| exOpA | output | DW | First operand of the execute-stage instruction |
| exOpB | output | DW | Second operand of the execute-stage instruction |

## Verification
The bench aims at the distances where a dependence can fall into a gap. These are one and two positions behind (bypass), three behind (same-cycle register-file pass-through), and the case where two in-flight producers write the same register. A design that reversed the priority would hand the older value to the consumer. A design that dropped the write-before-read path would return the stale register for the third consumer. Register 0 and producers with no write enable are used as decoys: a design that ignored them would forward garbage or stall for nothing. With forwarding off, the bench counts stall cycles per instruction, which exposes a hazard check that misses a stage or that holds for one cycle too many.

// File: rtl/opbyp_pkg.sv
`timescale 1ns/1ps
package opbyp_pkg;

  // Operand source select, encoding is visible at the top ports.
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } opSel_e;

  // Strobes from hazard control to the operand datapath.
  typedef struct packed {
    opSel_e selA;
    opSel_e selB;
    logic   bubble;
    logic   wbWrite;
  } ctlStrobes_t;

endpackage

// File: rtl/opbyp_regfile.sv
`timescale 1ns/1ps
module opbyp_regfile #(
  parameter int AW  = 5,
  parameter int DW  = 32,
  parameter int NRD = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we && (waddr != '0)) begin
      mem[waddr] <= wdata;
    end
  end

  // Read ports: register 0 is zero, a same-cycle write passes straight through.
  generate
    for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign rdata[k] = (raddr[k] == '0)                ? '0    :
                        (we && (waddr == raddr[k]))     ? wdata :
                                                          mem[raddr[k]];
    end
  endgenerate

  // R5: location 0 is never modified
  p_r0_stays_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    mem[0] == '0);

  // R7: a writeback lands in the array for later readers
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    (we && (waddr != '0)) |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/opbyp_ctl.sv
`timescale 1ns/1ps
module opbyp_ctl
  import opbyp_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fwdEnable,
  input  logic [AW-1:0] idRs1,
  input  logic [AW-1:0] idRs2,
  input  logic [AW-1:0] idRd,
  input  logic          idRegWrite,
  output logic          stall,
  output ctlStrobes_t   strobes,
  output logic [AW-1:0] wbAddr
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] idSrc;
  logic [NSRC-1:0][AW-1:0] exSrc;
  logic [AW-1:0]           exRd, memRd, wbRd;
  logic                    exWe, memWe, wbWe;
  logic [NSRC-1:0]         idHitEx, idHitMem;
  opSel_e                  srcSel [NSRC];

  function automatic logic depends(input logic [AW-1:0] src,
                                   input logic [AW-1:0] dst,
                                   input logic          wr);
    return wr && (dst != '0) && (dst == src);
  endfunction

  assign idSrc = {idRs2, idRs1};

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      assign idHitEx[k]  = depends(idSrc[k], exRd,  exWe);
      assign idHitMem[k] = depends(idSrc[k], memRd, memWe);
      assign srcSel[k]   = (fwdEnable && depends(exSrc[k], memRd, memWe)) ? SEL_MEM :
                           (fwdEnable && depends(exSrc[k], wbRd,  wbWe))  ? SEL_WB  :
                                                                            SEL_RF;

      // R5: a zero source register always reads the register file
      p_zero_src_rf_r5: assert property (@(posedge clk) disable iff (!rstN)
        (exSrc[k] == '0) |-> (srcSel[k] == SEL_RF));

      // R6: a bypass source must be a writing instruction
      p_fwd_needs_we_r6: assert property (@(posedge clk) disable iff (!rstN)
        ((srcSel[k] == SEL_MEM) |-> memWe) and ((srcSel[k] == SEL_WB) |-> wbWe));

      // R4: two producers of one register, the younger wins
      p_younger_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
        (fwdEnable && memWe && wbWe && (memRd == wbRd) && (memRd != '0)
         && (exSrc[k] == memRd)) |-> (srcSel[k] == SEL_MEM));
    end
  endgenerate

  assign stall = !fwdEnable && ((|idHitEx) || (|idHitMem));

  // Register-number pipeline: decode -> execute -> memory -> writeback.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exSrc <= '0;
      exRd  <= '0;
      exWe  <= 1'b0;
      memRd <= '0;
      memWe <= 1'b0;
      wbRd  <= '0;
      wbWe  <= 1'b0;
    end else begin
      if (stall) begin
        exSrc <= '0;
        exRd  <= '0;
        exWe  <= 1'b0;
      end else begin
        exSrc <= idSrc;
        exRd  <= idRd;
        exWe  <= idRegWrite;
      end
      memRd <= exRd;
      memWe <= exWe;
      wbRd  <= memRd;
      wbWe  <= memWe;
    end
  end

  always_comb begin
    strobes.selA    = srcSel[0];
    strobes.selB    = srcSel[1];
    strobes.bubble  = stall;
    strobes.wbWrite = wbWe;
  end
  assign wbAddr = wbRd;

  // R7: with bypassing on, decode is never held
  p_fwd_never_stalls_r7: assert property (@(posedge clk) disable iff (!rstN)
    fwdEnable |-> !stall);

  // R9: a stall leaves a non-writing bubble in execute
  p_stall_bubble_r9: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (!exWe && (exRd == '0)));

  // R8: no dependence holds decode for more than two cycles
  p_stall_bounded_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stall && $past(stall)) |=> !stall);

endmodule

// File: rtl/opbyp_dp.sv
`timescale 1ns/1ps
module opbyp_dp
  import opbyp_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] idRs1,
  input  logic [AW-1:0] idRs2,
  input  logic [DW-1:0] exResult,
  input  ctlStrobes_t   strobes,
  input  logic [AW-1:0] wbAddr,
  output logic [DW-1:0] exOpA,
  output logic [DW-1:0] exOpB
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] rdAddr;
  logic [NSRC-1:0][DW-1:0] rdData;
  logic [NSRC-1:0][DW-1:0] latched;
  logic [NSRC-1:0][DW-1:0] opOut;
  logic [DW-1:0]           memRes, wbRes;
  opSel_e                  sel [NSRC];

  assign rdAddr = {idRs2, idRs1};
  assign sel[0] = strobes.selA;
  assign sel[1] = strobes.selB;

  opbyp_regfile #(.AW(AW), .DW(DW), .NRD(NSRC)) u_rf (
    .clk   (clk),
    .rstN  (rstN),
    .we    (strobes.wbWrite),
    .waddr (wbAddr),
    .wdata (wbRes),
    .raddr (rdAddr),
    .rdata (rdData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latched <= '0;
      memRes  <= '0;
      wbRes   <= '0;
    end else begin
      latched <= strobes.bubble ? '0 : rdData;
      memRes  <= exResult;
      wbRes   <= memRes;
    end
  end

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_mux
      assign opOut[k] = (sel[k] == SEL_MEM) ? memRes :
                        (sel[k] == SEL_WB)  ? wbRes  :
                                              latched[k];
    end
  endgenerate

  assign exOpA = opOut[0];
  assign exOpB = opOut[1];

  // R9: a bubble carries no register-file data into execute
  p_bubble_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bubble |=> (latched == '0));

endmodule

// File: rtl/opnd_bypass_unit.sv
`timescale 1ns/1ps
module opnd_bypass_unit
  import opbyp_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fwdEnable,
  input  logic [AW-1:0] idRs1,
  input  logic [AW-1:0] idRs2,
  input  logic [AW-1:0] idRd,
  input  logic          idRegWrite,
  input  logic [DW-1:0] exResult,
  output logic          stall,
  output logic [1:0]    exSelA,
  output logic [1:0]    exSelB,
  output logic [DW-1:0] exOpA,
  output logic [DW-1:0] exOpB
);
  ctlStrobes_t   strobes;
  logic [AW-1:0] wbAddr;

  opbyp_ctl #(.AW(AW)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .fwdEnable  (fwdEnable),
    .idRs1      (idRs1),
    .idRs2      (idRs2),
    .idRd       (idRd),
    .idRegWrite (idRegWrite),
    .stall      (stall),
    .strobes    (strobes),
    .wbAddr     (wbAddr)
  );

  opbyp_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .idRs1    (idRs1),
    .idRs2    (idRs2),
    .exResult (exResult),
    .strobes  (strobes),
    .wbAddr   (wbAddr),
    .exOpA    (exOpA),
    .exOpB    (exOpB)
  );

  assign exSelA = strobes.selA;
  assign exSelB = strobes.selB;

  // R8: no bypass select while forwarding is off
  p_nofwd_rf_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    !fwdEnable |-> ((exSelA == 2'b00) && (exSelB == 2'b00)));

endmodule

// File: tb/opnd_bypass_unit_bench.sv
`timescale 1ns/1ps
module opnd_bypass_unit_bench;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int N  = 26;

  typedef struct packed {
    logic          fwd;
    logic [4:0]    rs1;
    logic [4:0]    rs2;
    logic [4:0]    rd;
    logic          we;
    logic [31:0]   res;
  } vec_t;

  // fwd, rs1, rs2, rd, we, result
  localparam vec_t PROG [N] = '{
    '{1'b1, 5'd0,  5'd0,  5'd1,  1'b1, 32'h11111111}, // 0 producer r1
    '{1'b1, 5'd1,  5'd2,  5'd4,  1'b1, 32'h22220004}, // 1 one behind
    '{1'b1, 5'd5,  5'd1,  5'd6,  1'b1, 32'h00000006}, // 2 two behind
    '{1'b1, 5'd1,  5'd1,  5'd7,  1'b1, 32'h00000007}, // 3 three behind
    '{1'b1, 5'd4,  5'd6,  5'd1,  1'b1, 32'hAAAA0001}, // 4 mixed
    '{1'b1, 5'd0,  5'd0,  5'd8,  1'b1, 32'h00000088}, // 5 older r8
    '{1'b1, 5'd0,  5'd0,  5'd8,  1'b1, 32'h00000099}, // 6 younger r8
    '{1'b1, 5'd8,  5'd8,  5'd9,  1'b1, 32'h00000009}, // 7 priority
    '{1'b1, 5'd0,  5'd0,  5'd0,  1'b1, 32'h0000DEAD}, // 8 write r0
    '{1'b1, 5'd0,  5'd0,  5'd10, 1'b0, 32'h00000BAD}, // 9 no write
    '{1'b1, 5'd0,  5'd10, 5'd11, 1'b1, 32'h0000000B}, // 10 decoys
    '{1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 32'h00000000},
    '{1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 32'h00000000},
    '{1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 32'h00000000},
    '{1'b0, 5'd0,  5'd0,  5'd12, 1'b1, 32'h0000000C}, // 14 producer r12
    '{1'b0, 5'd12, 5'd0,  5'd13, 1'b1, 32'h0000000D}, // 15 stall 2
    '{1'b0, 5'd0,  5'd0,  5'd14, 1'b1, 32'h0000000E}, // 16 producer r14
    '{1'b0, 5'd0,  5'd0,  5'd15, 1'b1, 32'h0000000F}, // 17 unrelated
    '{1'b0, 5'd0,  5'd14, 5'd16, 1'b1, 32'h00000010}, // 18 stall 1
    '{1'b0, 5'd0,  5'd0,  5'd0,  1'b1, 32'h00000077}, // 19 writes r0
    '{1'b0, 5'd0,  5'd0,  5'd0,  1'b0, 32'h00000000}, // 20 reads r0
    '{1'b0, 5'd0,  5'd0,  5'd18, 1'b0, 32'h00000012}, // 21 no write
    '{1'b0, 5'd18, 5'd18, 5'd19, 1'b1, 32'h00000013}, // 22 reads r18
    '{1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 32'h00000000},
    '{1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 32'h00000000},
    '{1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 32'h00000000}
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          fwdEnable;
  logic [AW-1:0] idRs1, idRs2, idRd;
  logic          idRegWrite;
  logic [DW-1:0] exResult;
  logic          stall;
  logic [1:0]    exSelA, exSelB;
  logic [DW-1:0] exOpA, exOpB;

  always #2.5 clk = ~clk;

  opnd_bypass_unit #(.AW(AW), .DW(DW)) u_opnd_bypass_unit (
    .clk(clk), .rstN(rstN), .fwdEnable(fwdEnable),
    .idRs1(idRs1), .idRs2(idRs2), .idRd(idRd), .idRegWrite(idRegWrite),
    .exResult(exResult), .stall(stall), .exSelA(exSelA), .exSelB(exSelB),
    .exOpA(exOpA), .exOpB(exOpB)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int exIdx = -1, memIdx = -1, wbIdx = -1, idIdx = 0;
  logic [DW-1:0] arch [32];
  logic [DW-1:0] expA [N];
  logic [DW-1:0] expB [N];
  int stallsOf [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%h expected=0x%h", req, what, act, exp);
    end
  endtask

  function automatic bit prodHits(input logic [4:0] src, input int p);
    if (p < 0) return 1'b0;
    return PROG[p].we && (PROG[p].rd != 5'd0) && (PROG[p].rd == src);
  endfunction

  function automatic logic [1:0] expSel(input logic [4:0] src, input bit fwd);
    if (fwd && prodHits(src, memIdx)) return 2'b10;
    if (fwd && prodHits(src, wbIdx))  return 2'b01;
    return 2'b00;
  endfunction

  function automatic string selTag(input logic [4:0] src, input bit fwd);
    if (fwd && prodHits(src, memIdx) && prodHits(src, wbIdx)) return "R4";
    if (fwd && prodHits(src, memIdx)) return "R2";
    if (fwd && prodHits(src, wbIdx))  return "R3";
    if (src == 5'd0) return "R5";
    if (!fwd) return "R8";
    return "R6";
  endfunction

  task automatic driveId(input int i);
    if (i < N) begin
      fwdEnable = PROG[i].fwd; idRs1 = PROG[i].rs1; idRs2 = PROG[i].rs2;
      idRd = PROG[i].rd; idRegWrite = PROG[i].we;
    end else begin
      fwdEnable = 1'b1; idRs1 = '0; idRs2 = '0; idRd = '0; idRegWrite = 1'b0;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit es, fwdNow;
    int sumEarly;
    for (int r = 0; r < 32; r++) arch[r] = '0;
    for (int i = 0; i < N; i++) stallsOf[i] = 0;
    rstN = 1'b0;
    driveId(N);
    exResult = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(stall == 1'b0, "R1", "reset stall", 32'(stall), 0);
    chk(exSelA == 2'b00, "R1", "reset selA", 32'(exSelA), 0);
    chk(exSelB == 2'b00, "R1", "reset selB", 32'(exSelB), 0);
    chk(exOpA == '0, "R1", "reset opA", exOpA, 0);
    chk(exOpB == '0, "R1", "reset opB", exOpB, 0);
    @(posedge clk);
    #1 rstN = 1'b1;
    driveId(0);

    // Table walk: one decode-stage vector per cycle, held while stalled.
    for (int cyc = 0; cyc < 400 && idIdx < N; cyc++) begin
      @(negedge clk);
      fwdNow = PROG[idIdx].fwd;
      es = !fwdNow && (prodHits(PROG[idIdx].rs1, exIdx) || prodHits(PROG[idIdx].rs2, exIdx) ||
                       prodHits(PROG[idIdx].rs1, memIdx) || prodHits(PROG[idIdx].rs2, memIdx));
      chk(stall == es, es ? "R8" : (fwdNow ? "R7" : "R10"), $sformatf("stall at vec %0d", idIdx),
          32'(stall), 32'(es));
      if (exIdx >= 0) begin
        chk(exSelA == expSel(PROG[exIdx].rs1, fwdNow), selTag(PROG[exIdx].rs1, fwdNow),
            $sformatf("selA vec %0d", exIdx), 32'(exSelA), 32'(expSel(PROG[exIdx].rs1, fwdNow)));
        chk(exSelB == expSel(PROG[exIdx].rs2, fwdNow), selTag(PROG[exIdx].rs2, fwdNow),
            $sformatf("selB vec %0d", exIdx), 32'(exSelB), 32'(expSel(PROG[exIdx].rs2, fwdNow)));
        chk(exOpA == expA[exIdx], selTag(PROG[exIdx].rs1, fwdNow),
            $sformatf("opA vec %0d (R7 value)", exIdx), exOpA, expA[exIdx]);
        chk(exOpB == expB[exIdx], selTag(PROG[exIdx].rs2, fwdNow),
            $sformatf("opB vec %0d (R7 value)", exIdx), exOpB, expB[exIdx]);
      end else begin
        chk((exSelA == 2'b00) && (exSelB == 2'b00), "R9", "bubble selects",
            {28'd0, exSelA, exSelB}, 0);
      end
      @(posedge clk);
      wbIdx = memIdx;
      memIdx = exIdx;
      if (es) begin
        exIdx = -1;
        stallsOf[idIdx]++;
      end else begin
        expA[idIdx] = (PROG[idIdx].rs1 == 5'd0) ? '0 : arch[PROG[idIdx].rs1];
        expB[idIdx] = (PROG[idIdx].rs2 == 5'd0) ? '0 : arch[PROG[idIdx].rs2];
        if (PROG[idIdx].we && PROG[idIdx].rd != 5'd0) arch[PROG[idIdx].rd] = PROG[idIdx].res;
        exIdx = idIdx;
        idIdx++;
      end
      #1;
      driveId(idIdx);
      exResult = (exIdx >= 0) ? PROG[exIdx].res : '0;
    end

    // Directed stall counts.
    sumEarly = 0;
    for (int i = 0; i < 14; i++) sumEarly += stallsOf[i];
    chk(sumEarly == 0, "R7", "stalls with forwarding on", 32'(sumEarly), 0);
    chk(stallsOf[15] == 2, "R8", "stalls one behind", 32'(stallsOf[15]), 2);
    chk(stallsOf[18] == 1, "R8", "stalls two behind", 32'(stallsOf[18]), 1);
    chk(stallsOf[20] == 0, "R10", "stalls on r0 producer", 32'(stallsOf[20]), 0);
    chk(stallsOf[22] == 0, "R10", "stalls on non-writing producer", 32'(stallsOf[22]), 0);

    // Directed reset in mid-run.
    @(posedge clk);
    #1 fwdEnable = 1'b1; idRs1 = 5'd4; idRs2 = 5'd1; idRd = '0; idRegWrite = 1'b0; exResult = '0;
    @(posedge clk);
    #1 driveId(N);
    @(negedge clk);
    chk(exOpA == 32'h22220004, "R7", "pre-reset read r4", exOpA, 32'h22220004);
    chk(exOpB == 32'hAAAA0001, "R7", "pre-reset read r1", exOpB, 32'hAAAA0001);
    rstN = 1'b0;
    #1;
    chk(exOpA == '0, "R1", "mid-run reset opA", exOpA, 0);
    chk(exOpB == '0, "R1", "mid-run reset opB", exOpB, 0);
    @(posedge clk);
    #1 rstN = 1'b1;
    fwdEnable = 1'b0; idRs1 = 5'd4; idRs2 = 5'd1; idRd = 5'd3; idRegWrite = 1'b1;
    @(negedge clk);
    chk(stall == 1'b0, "R1", "no stall after reset", 32'(stall), 0);
    @(posedge clk);
    #1 driveId(N);
    @(negedge clk);
    chk(exOpA == '0, "R1", "r4 cleared by reset", exOpA, 0);
    chk(exOpB == '0, "R1", "r1 cleared by reset", exOpB, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule